// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block orders the chip-level reset. A power-on pulse, a watchdog overflow or an external low level on the reset pin starts a reset. The block then counts cycles of the reference clock and releases the system in stages. After power-on it first keeps the internal clocks gated so that the oscillator can settle. It then keeps pulling the reset pin low for a short time. Last, it holds the CPU and memories in reset for a few more cycles before the reset vector fetch may begin.

A watchdog overflow skips the settling phase and goes straight to the pin and CPU stages. A small status register holds exactly one bit for the cause of the most recent reset. It can be read at any time through a gated read port. A purely combinational qualifier tells the watchdog to stay disabled whenever a high voltage is seen on the reset pin or on the interrupt pin.

Top module: `rstseq_top`

## Requirements
- R1: A high `por_pulse` at a clock edge restarts the sequence from count zero in any state. It wins over a watchdog overflow at the same edge.
- R2: After a power-on pulse, `clk_en` is low for exactly STAB_CYCLES (default 4096) cycles and then high.
- R3: After a power-on pulse, `rst_pin_pd` is high for exactly STAB_CYCLES + PIN_CYCLES (default 4128) cycles.
- R4: `cpu_rst` stays high until HOLD_CYCLES (default 32) cycles after the reset pin is seen high again. After a power-on pulse this is 4160 cycles in total.
- R5: A power-on reset loads the status with only bit 0 set (value 3'b001).
- R6: A watchdog overflow outside the settling phase does three things. It pulls the pin low for PIN_CYCLES. It then holds the CPU for HOLD_CYCLES more. It never gates the clocks. It loads the status with only bit 1 set (3'b010).
- R7: A watchdog overflow during the settling phase is ignored. The timing of the outputs and the status stay as they were.
- R8: In idle, a low level on the reset pin that the block is not driving starts a pin reset. `cpu_rst` rises at the next cycle and the pin is not driven. The status becomes only bit 2 (3'b100). A low pin during the CPU hold restarts the hold count.
- R9: The status changes only when a new reset starts. `stat_data` shows it while `stat_rd` is high and reads zero otherwise.
- R10: `wdog_disable` is the OR of `hv_on_rst` and `hv_on_irq`, with no clocked path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference (crystal) clock |
| por_pulse | input | 1 | Power-on pulse, synchronous to clk_ref |
| wdog_ovf | input | 1 | Watchdog overflow request |
| rst_pin_level | input | 1 | Level seen on the reset pin |
| hv_on_rst | input | 1 | High voltage seen on the reset pin |
| hv_on_irq | input | 1 | High voltage seen on the interrupt pin |
| stat_rd | input | 1 | Status read strobe |
| clk_en | output | 1 | Enable for the CPU and peripheral clocks |
| rst_pin_pd | output | 1 | Pull-down request for the reset pin |
| cpu_rst | output | 1 | Reset for the CPU and memories |
| wdog_disable | output | 1 | Watchdog disable qualifier |
| stat_data | output | 3 | Reset cause: bit0 power-on, bit1 watchdog, bit2 pin |

## Verification
The bench places a watchdog overflow inside the settling window. A design that accepts it would cut the oscillator wait short and overwrite the power-on cause. It fires a power-on pulse and a watchdog overflow at the same edge, and again in the middle of a watchdog sequence. A wrong priority or an incomplete restart would show up as a short clock-gate phase or the wrong cause bit. It also pulls the pin low from outside while the block is idle, and again during the CPU hold. A design that fails to restart the hold count would release the CPU too early.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STAB = 2'd1,
      ST_PIN  = 2'd2,
      ST_HOLD = 2'd3
   } seq_state_t;

   localparam int N_CAUSE   = 3;
   localparam int CAUSE_POR = 0;
   localparam int CAUSE_COP = 1;
   localparam int CAUSE_PIN = 2;

   typedef logic [N_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/rstseq_counter.sv
module rstseq_counter #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (clr)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
   import rstseq_pkg::*;
#(
   parameter int STAB_CYCLES = 4096,
   parameter int PIN_CYCLES  = 32,
   parameter int HOLD_CYCLES = 32,
   parameter int CNT_W       = 13
) (
   input  logic             clk,
   input  logic             por,
   input  logic             wdog,
   input  logic             pin_level,
   input  logic [CNT_W-1:0] cnt,
   output seq_state_t       state,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output logic             cause_load,
   output cause_vec_t       cause
);
   localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_CYCLES - 1);
   localparam logic [CNT_W-1:0] PIN_LAST  = CNT_W'(PIN_CYCLES - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

   seq_state_t nxt;

   always_comb begin
      nxt        = state;
      cnt_clr    = 1'b0;
      cnt_inc    = 1'b0;
      cause_load = 1'b0;
      cause      = '0;
      if (por) begin
         nxt              = ST_STAB;
         cnt_clr          = 1'b1;
         cause_load       = 1'b1;
         cause[CAUSE_POR] = 1'b1;
      end else if (wdog && state != ST_STAB) begin
         nxt              = ST_PIN;
         cnt_clr          = 1'b1;
         cause_load       = 1'b1;
         cause[CAUSE_COP] = 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (!pin_level) begin
                  nxt              = ST_HOLD;
                  cnt_clr          = 1'b1;
                  cause_load       = 1'b1;
                  cause[CAUSE_PIN] = 1'b1;
               end
            end
            ST_STAB: begin
               if (cnt == STAB_LAST) begin
                  nxt     = ST_PIN;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_PIN: begin
               if (cnt == PIN_LAST) begin
                  nxt     = ST_HOLD;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_HOLD: begin
               if (!pin_level) begin
                  cnt_clr = 1'b1;
               end else if (cnt == HOLD_LAST) begin
                  nxt     = ST_IDLE;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      state <= nxt;
   end
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
   import rstseq_pkg::*;
#(
   parameter bit RD_GATED = 1'b1
) (
   input  logic       clk,
   input  logic       load,
   input  cause_vec_t cause,
   input  logic       rd,
   output cause_vec_t stat_q,
   output cause_vec_t rd_data
);
   always_ff @(posedge clk) begin
      if (load)
         stat_q <= cause;
   end

   if (RD_GATED) begin : g_rd_gated
      assign rd_data = rd ? stat_q : '0;
   end else begin : g_rd_open
      logic unused_rd;
      assign unused_rd = rd;
      assign rd_data   = stat_q;
   end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int STAB_CYCLES = 4096,
   parameter int PIN_CYCLES  = 32,
   parameter int HOLD_CYCLES = 32,
   parameter bit RD_GATED    = 1'b1
) (
   input  logic         clk_ref,
   input  logic         por_pulse,
   input  logic         wdog_ovf,
   input  logic         rst_pin_level,
   input  logic         hv_on_rst,
   input  logic         hv_on_irq,
   input  logic         stat_rd,
   output logic         clk_en,
   output logic         rst_pin_pd,
   output logic         cpu_rst,
   output logic         wdog_disable,
   output logic [2:0]   stat_data
);
   localparam int MAX_A   = (STAB_CYCLES > PIN_CYCLES) ? STAB_CYCLES : PIN_CYCLES;
   localparam int MAX_CYC = (MAX_A > HOLD_CYCLES) ? MAX_A : HOLD_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (STAB_CYCLES < 1 || PIN_CYCLES < 1 || HOLD_CYCLES < 1) begin : g_bad_len
      $error("rstseq_top: every phase length must be at least one cycle");
   end
   if (N_CAUSE != 3) begin : g_bad_cause
      $error("rstseq_top: status port expects three cause bits");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic             cnt_clr;
   logic             cnt_inc;
   logic             cause_load;
   cause_vec_t       cause;
   cause_vec_t       stat_q;
   cause_vec_t       rd_data;

   rstseq_fsm #(
      .STAB_CYCLES (STAB_CYCLES),
      .PIN_CYCLES  (PIN_CYCLES),
      .HOLD_CYCLES (HOLD_CYCLES),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk        (clk_ref),
      .por        (por_pulse),
      .wdog       (wdog_ovf),
      .pin_level  (rst_pin_level),
      .cnt        (cnt),
      .state      (state),
      .cnt_clr    (cnt_clr),
      .cnt_inc    (cnt_inc),
      .cause_load (cause_load),
      .cause      (cause)
   );

   rstseq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk_ref),
      .clr (cnt_clr),
      .inc (cnt_inc),
      .cnt (cnt)
   );

   rstseq_status #(.RD_GATED(RD_GATED)) u_stat (
      .clk     (clk_ref),
      .load    (cause_load),
      .cause   (cause),
      .rd      (stat_rd),
      .stat_q  (stat_q),
      .rd_data (rd_data)
   );

   // Output decode from the sequence state
   assign clk_en       = (state != ST_STAB);
   assign rst_pin_pd   = (state == ST_STAB) || (state == ST_PIN);
   assign cpu_rst      = (state != ST_IDLE);
   assign wdog_disable = hv_on_rst | hv_on_irq;
   assign stat_data    = rd_data;
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
   input logic       clk,
   input logic       por,
   input logic       wdog,
   input logic       pin_level,
   input logic       clk_en,
   input logic       pd,
   input logic       cpu,
   input logic [2:0] stat
);
   // R2: gated clocks always come with the pin pulled low
   assert_gate_pin_R3: assert property (@(posedge clk) disable iff (por)
      !clk_en |-> pd);

   // R4: the CPU reset outlasts the pin pull-down
   assert_pin_cpu_R4: assert property (@(posedge clk) disable iff (por)
      pd |-> cpu);

   assert_clk_start_R2: assert property (@(posedge clk) disable iff (por)
      $rose(clk_en) |-> pd);

   assert_stat_onehot_R5: assert property (@(posedge clk) disable iff (por)
      $onehot0(stat));

   assert_stat_hold_R9: assert property (@(posedge clk) disable iff (por)
      !$stable(stat) |-> $past(por || wdog || !pin_level));

   assert_wdog_no_gate_R6: assert property (@(posedge clk) disable iff (por)
      (wdog && clk_en) |=> (pd && clk_en));
endmodule

bind rstseq_top rstseq_checker u_rstseq_checker (
   .clk       (clk_ref),
   .por       (por_pulse),
   .wdog      (wdog_ovf),
   .pin_level (rst_pin_level),
   .clk_en    (clk_en),
   .pd        (rst_pin_pd),
   .cpu       (cpu_rst),
   .stat      (stat_q)
);

// File: tb/test_rstseq_top.sv
module test_rstseq_top;
   localparam int STAB = 4096;
   localparam int PINC = 32;
   localparam int HOLD = 32;

   logic clk = 1'b0;
   logic por = 1'b1;
   logic wdog = 1'b0;
   logic ext_low = 1'b0;
   logic hv_r = 1'b0;
   logic hv_i = 1'b0;
   logic rd = 1'b0;
   logic pin_level;
   logic clk_en, pd, cpu, wdis;
   logic [2:0] sdata;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit started = 1'b0;

   // behavioural model: cycles left for each output
   int m_gate = 0;
   int m_pd = 0;
   int m_cpu = 0;
   int m_stat = 0;
   logic m_pin_lo;

   always #10 clk = ~clk;

   assign pin_level = ~(pd | ext_low);

   rstseq_top i_rstseq_top (
      .clk_ref       (clk),
      .por_pulse     (por),
      .wdog_ovf      (wdog),
      .rst_pin_level (pin_level),
      .hv_on_rst     (hv_r),
      .hv_on_irq     (hv_i),
      .stat_rd       (rd),
      .clk_en        (clk_en),
      .rst_pin_pd    (pd),
      .cpu_rst       (cpu),
      .wdog_disable  (wdis),
      .stat_data     (sdata)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      m_pin_lo = (m_pd > 0) || ext_low;
      if (por) begin                                   // R1
         started = 1'b1;
         m_gate = STAB; m_pd = STAB + PINC; m_cpu = STAB + PINC + HOLD; m_stat = 1;
      end else if (wdog && m_gate == 0) begin         // R6, R7
         m_pd = PINC; m_cpu = PINC + HOLD; m_stat = 2;
      end else if (m_cpu == 0) begin
         if (m_pin_lo) begin                           // R8
            m_cpu = HOLD; m_stat = 4;
         end
      end else begin
         if (m_gate > 0) m_gate--;
         if (m_pd > 0) begin
            m_pd--; m_cpu--;
         end else if (m_pin_lo) begin
            m_cpu = HOLD;
         end else begin
            m_cpu--;
         end
      end
   end

   always @(negedge clk) begin
      #2;
      if (started) begin
         check("R2 clk_en", int'(clk_en), (m_gate == 0) ? 1 : 0);
         check("R3 rst_pin_pd", int'(pd), (m_pd > 0) ? 1 : 0);
         check("R4 cpu_rst", int'(cpu), (m_cpu > 0) ? 1 : 0);
         check("R9 stat_data", int'(sdata), rd ? m_stat : 0);
         check("R10 wdog_disable", int'(wdis), (hv_r || hv_i) ? 1 : 0);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd = ($urandom_range(0, 1) == 1);
      end
   endtask

   initial begin
      @(negedge clk);
      por = 1'b0;
      rd = 1'b1;
      #3;
      check("R5 status after POR", int'(sdata), 1);
      check("R2 clocks gated after POR", int'(clk_en), 0);
      step(100);
      wdog = 1'b1;                                    // R7 ignored in settling
      step(1);
      wdog = 1'b0;
      rd = 1'b1; #3;
      check("R7 status kept", int'(sdata), 1);
      check("R7 clocks still gated", int'(clk_en), 0);
      step(4200);
      hv_r = 1'b1; #1;
      check("R10 hv on reset pin", int'(wdis), 1);
      hv_r = 1'b0; hv_i = 1'b1; #1;
      check("R10 hv on irq pin", int'(wdis), 1);
      hv_i = 1'b0; #1;
      check("R10 no hv", int'(wdis), 0);
      wdog = 1'b1;                                    // R6
      step(1);
      wdog = 1'b0;
      rd = 1'b1; #3;
      check("R6 status watchdog", int'(sdata), 2);
      check("R6 clocks not gated", int'(clk_en), 1);
      step(40);
      por = 1'b1; wdog = 1'b1;                        // R1 priority
      step(1);
      por = 1'b0; wdog = 1'b0;
      rd = 1'b1; #3;
      check("R1 POR wins over watchdog", int'(sdata), 1);
      check("R1 restart gates clocks", int'(clk_en), 0);
      step(4200);
      ext_low = 1'b1;                                 // R8
      step(10);
      rd = 1'b1; #3;
      check("R8 status pin", int'(sdata), 4);
      check("R8 pin not driven", int'(pd), 0);
      ext_low = 1'b0;
      step(20);
      ext_low = 1'b1;
      step(3);
      ext_low = 1'b0;
      step(20);
      #3;
      check("R8 hold count restarted", int'(cpu), 1);
      step(20);
      rd = 1'b0; #3;
      check("R9 read gated off", int'(sdata), 0);
      step(5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 190000);
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule